// File: doc/BRIEF.md
# Multiplexed VFD Grid Dimming Generator

This block time-multiplexes a vacuum fluorescent display that has two or three grids. Each grid owns one 27-bit segment pattern, and all three patterns arrive side by side on a parallel frame input. A free-running divider turns the system clock into a bit-time tick. A slot counter of 1024 bit times hands each slot to one grid in turn. A strap input picks two-grid (1/2 duty) or three-grid (1/3 duty) rotation.

Within a slot, the active grid pre-driver line is pulled low for the first 1016 bit times. It is released for the last 8 bit times, which leaves a blanking gap before the next grid. A 10-bit dimming code sets how many leading bit times of the slot carry segment drive. During that same window a dimming pulse is raised for a cascaded slave driver. Two sync lines give the slave the binary number of the active grid.

The dimming code and the frame are sampled only at slot boundaries. Changes made while a slot is running therefore never alter it. Loading of the frame and code from a serial host link is done elsewhere.

Top module: `vfd_grid_dimmer`

## Requirements
- R1: One bit time lasts TICK_DIV (default 4) clock cycles. A slot lasts 1024 bit times, so the first slot boundary after reset release falls on the 4096th clock edge.
- R2: With `duplex_sel` high the active grid alternates 1, 2, 1, 2. With it low the order is 1, 2, 3, 1. Grid 1 holds the first slot after reset.
- R3: `grid_n` is active low, with bit 0 for grid 1 and bit 2 for grid 3. The active grid's bit is 0 during bit times 0 to 1015 of its slot. All bits are 1 during bit times 1016 to 1023. Bits of inactive grids are always 1.
- R4: For a latched dimming code D of 0 to 1015, segment drive is on during bit times 0 to D-1 of the slot and off for the rest. Bit 0 of `dim_code` is the least significant bit.
- R5: A dimming code of 1016 or more gives exactly 1016 on bit times.
- R6: During the on window, `seg_out[i]` equals bit i of the latched pattern for the active grid. The pattern for grid k (k = 0, 1, 2) sits at `seg_frame[k*27 +: 27]`. Outside the window `seg_out` is all zero.
- R7: `dim_pulse` is high exactly during the on window of R4 and R5.
- R8: `sync_idx` holds the binary number of the active grid: 0 for grid 1, 1 for grid 2, 2 for grid 3.
- R9: `dim_code` and `seg_frame` are sampled only at the start of each slot. A change in the middle of a slot has no effect until the next slot. The first slot after reset uses a code of 0 and an all-zero pattern.
- R10: While reset is asserted and right after it, `grid_n` is 3'b110, `seg_out` is 0, `dim_pulse` is 0 and `sync_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| duplex_sel | input | 1 | Strap: 1 gives two-grid rotation, 0 gives three-grid rotation |
| dim_code | input | 10 | Dimming code in bit times, LSB at bit 0 |
| seg_frame | input | 81 | Segment patterns of grids 1 to 3, 27 bits each, grid 1 in the low bits |
| grid_n | output | 3 | Active-low grid pre-driver lines |
| seg_out | output | 27 | Segment (anode) drive lines |
| dim_pulse | output | 1 | Dimming pulse for a cascaded slave driver |
| sync_idx | output | 2 | Binary number of the active grid for a slave driver |

## Verification
All outputs are combinational decodes of registered state, so they change on the same edge that moves the bit counter. After the m-th clock edge since reset release, the bench expects bit time floor(m/4) mod 1024 of slot floor(m/4096). It waits until its own edge counter reaches m and samples at the following falling edge. A new code or frame shows up only in the slot after the next boundary. The deferral test therefore checks the old values late in the current slot and the new values in the next slot. Probes placed on the last and first clock of a bit time, and of a slot, pin down the cycle in which each window edge appears.

// File: rtl/vfd_mux_pkg.sv
package vfd_mux_pkg;

    localparam int DEF_SEG_W    = 27;
    localparam int DEF_DIM_W    = 10;
    localparam int DEF_BLANK    = 8;
    localparam int DEF_TICK_DIV = 4;
    localparam int GRID_CNT     = 3;

    typedef enum logic [1:0] {
        GRID_1 = 2'd0,
        GRID_2 = 2'd1,
        GRID_3 = 2'd2
    } grid_sel_e;

    typedef struct packed {
        grid_sel_e grid;
        logic      grid_on;
        logic      seg_on;
    } drive_ctl_t;

    function automatic grid_sel_e next_grid(input grid_sel_e cur, input logic duplex);
        grid_sel_e nxt;
        if (cur == GRID_1)
            nxt = GRID_2;
        else if (cur == GRID_2 && !duplex)
            nxt = GRID_3;
        else
            nxt = GRID_1;
        return nxt;
    endfunction

    function automatic int on_limit(input int dim_w, input int blank);
        return (1 << dim_w) - blank;
    endfunction

endpackage

// File: rtl/vfd_bit_timer.sv
module vfd_bit_timer
    import vfd_mux_pkg::*;
#(
    parameter int TICK_DIV = DEF_TICK_DIV,
    parameter int DIM_W    = DEF_DIM_W
) (
    input  logic             clk,
    input  logic             rst,
    output logic [DIM_W-1:0] bit_pos,
    output logic             tick,
    output logic             slot_end
);

    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV > 1) begin : g_div
            localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
            logic [DIV_W-1:0] div_q;

            always_ff @(posedge clk) begin
                if (rst)
                    div_q <= '0;
                else if (div_q == DIV_LAST)
                    div_q <= '0;
                else
                    div_q <= div_q + 1'b1;
            end

            assign tick = (div_q == DIV_LAST);
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            bit_pos <= '0;
        else if (tick)
            bit_pos <= bit_pos + 1'b1;
    end

    assign slot_end = tick && (bit_pos == '1);

    assert_bitpos_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(bit_pos));

    assert_bitpos_step_R1: assert property (@(posedge clk) disable iff (rst)
        tick |=> bit_pos == DIM_W'($past(bit_pos) + 1'b1));

endmodule

// File: rtl/vfd_slot_sequencer.sv
module vfd_slot_sequencer
    import vfd_mux_pkg::*;
#(
    parameter int SEG_W = DEF_SEG_W,
    parameter int DIM_W = DEF_DIM_W,
    parameter int BLANK = DEF_BLANK
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      slot_end,
    input  logic                      duplex_sel,
    input  logic [DIM_W-1:0]          dim_code,
    input  logic [GRID_CNT*SEG_W-1:0] seg_frame,
    output grid_sel_e                 grid,
    output logic [DIM_W-1:0]          dim_eff,
    output logic [SEG_W-1:0]          seg_cur
);

    localparam int              ON_MAX   = on_limit(DIM_W, BLANK);
    localparam logic [DIM_W-1:0] ON_MAX_V = DIM_W'(ON_MAX);

    logic [SEG_W-1:0] frame_slice [GRID_CNT];
    grid_sel_e        grid_nxt;
    logic [DIM_W-1:0] dim_clamped;

    generate
        for (genvar g = 0; g < GRID_CNT; g++) begin : g_slice
            assign frame_slice[g] = seg_frame[g*SEG_W +: SEG_W];
        end
    endgenerate

    always_comb begin
        grid_nxt    = next_grid(grid, duplex_sel);
        dim_clamped = (dim_code >= ON_MAX_V) ? ON_MAX_V : dim_code;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grid    <= GRID_1;
            dim_eff <= '0;
            seg_cur <= '0;
        end else if (slot_end) begin
            grid    <= grid_nxt;
            dim_eff <= dim_clamped;
            seg_cur <= frame_slice[grid_nxt];
        end
    end

    assert_grid_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !slot_end |=> $stable(grid));

    assert_duplex_order_R2: assert property (@(posedge clk) disable iff (rst)
        (slot_end && duplex_sel) |=> grid != GRID_3);

    assert_triplex_order_R2: assert property (@(posedge clk) disable iff (rst)
        (slot_end && !duplex_sel && grid == GRID_2) |=> grid == GRID_3);

    assert_latch_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !slot_end |=> ($stable(dim_eff) && $stable(seg_cur)));

    assert_clamp_R5: assert property (@(posedge clk) disable iff (rst)
        dim_eff <= ON_MAX_V);

endmodule

// File: rtl/vfd_drive_stage.sv
module vfd_drive_stage
    import vfd_mux_pkg::*;
#(
    parameter int SEG_W = DEF_SEG_W,
    parameter int DIM_W = DEF_DIM_W,
    parameter int BLANK = DEF_BLANK
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DIM_W-1:0]    bit_pos,
    input  grid_sel_e           grid,
    input  logic [DIM_W-1:0]    dim_eff,
    input  logic [SEG_W-1:0]    seg_cur,
    output logic [GRID_CNT-1:0] grid_n,
    output logic [SEG_W-1:0]    seg_out,
    output logic                dim_pulse,
    output logic [1:0]          sync_idx
);

    localparam logic [DIM_W-1:0] ON_MAX_V = DIM_W'(on_limit(DIM_W, BLANK));

    drive_ctl_t ctl;

    always_comb begin
        ctl.grid    = grid;
        ctl.grid_on = (bit_pos < ON_MAX_V);
        ctl.seg_on  = (bit_pos < dim_eff);
    end

    generate
        for (genvar g = 0; g < GRID_CNT; g++) begin : g_grid
            assign grid_n[g] = !(ctl.grid_on && (ctl.grid == grid_sel_e'(2'(g))));
        end
    endgenerate

    assign seg_out   = ctl.seg_on ? seg_cur : '0;
    assign dim_pulse = ctl.seg_on;
    assign sync_idx  = ctl.grid;

    assert_one_grid_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~grid_n));

    assert_tail_blank_R3: assert property (@(posedge clk) disable iff (rst)
        (bit_pos >= ON_MAX_V) |-> (grid_n == '1 && !dim_pulse));

    assert_pulse_in_grid_R7: assert property (@(posedge clk) disable iff (rst)
        dim_pulse |-> grid_n != '1);

    assert_sync_match_R8: assert property (@(posedge clk) disable iff (rst)
        (grid_n != '1) |-> !grid_n[sync_idx]);

endmodule

// File: rtl/vfd_grid_dimmer.sv
module vfd_grid_dimmer
    import vfd_mux_pkg::*;
#(
    parameter int TICK_DIV = DEF_TICK_DIV,
    parameter int SEG_W    = DEF_SEG_W,
    parameter int DIM_W    = DEF_DIM_W,
    parameter int BLANK    = DEF_BLANK
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      duplex_sel,
    input  logic [DIM_W-1:0]          dim_code,
    input  logic [GRID_CNT*SEG_W-1:0] seg_frame,
    output logic [GRID_CNT-1:0]       grid_n,
    output logic [SEG_W-1:0]          seg_out,
    output logic                      dim_pulse,
    output logic [1:0]                sync_idx
);

    logic [DIM_W-1:0] bit_pos;
    logic             tick;
    logic             slot_end;
    grid_sel_e        grid;
    logic [DIM_W-1:0] dim_eff;
    logic [SEG_W-1:0] seg_cur;

    vfd_bit_timer #(
        .TICK_DIV (TICK_DIV),
        .DIM_W    (DIM_W)
    ) i_timer (
        .clk      (clk),
        .rst      (rst),
        .bit_pos  (bit_pos),
        .tick     (tick),
        .slot_end (slot_end)
    );

    vfd_slot_sequencer #(
        .SEG_W (SEG_W),
        .DIM_W (DIM_W),
        .BLANK (BLANK)
    ) i_seq (
        .clk        (clk),
        .rst        (rst),
        .slot_end   (slot_end),
        .duplex_sel (duplex_sel),
        .dim_code   (dim_code),
        .seg_frame  (seg_frame),
        .grid       (grid),
        .dim_eff    (dim_eff),
        .seg_cur    (seg_cur)
    );

    vfd_drive_stage #(
        .SEG_W (SEG_W),
        .DIM_W (DIM_W),
        .BLANK (BLANK)
    ) i_drive (
        .clk       (clk),
        .rst       (rst),
        .bit_pos   (bit_pos),
        .grid      (grid),
        .dim_eff   (dim_eff),
        .seg_cur   (seg_cur),
        .grid_n    (grid_n),
        .seg_out   (seg_out),
        .dim_pulse (dim_pulse),
        .sync_idx  (sync_idx)
    );

    assert_seg_blank_R6: assert property (@(posedge clk) disable iff (rst)
        !dim_pulse |-> seg_out == '0);

    assert_slot_rotate_R2: assert property (@(posedge clk) disable iff (rst)
        slot_end |=> sync_idx != $past(sync_idx));

endmodule

// File: tb/test_vfd_grid_dimmer.sv
module test_vfd_grid_dimmer;

    localparam int CLK_PERIOD = 10;
    localparam int SEG_W      = 27;
    localparam int DIM_W      = 10;
    localparam int BIT_CLK    = 4;
    localparam int SLOT_BITS  = 1024;
    localparam int SLOT_CLK   = BIT_CLK * SLOT_BITS;
    localparam int ON_MAX     = 1016;

    localparam logic [3*SEG_W-1:0] FRAME_A = {27'h7A1C3B5, 27'h2C3D1E7, 27'h15A5A5A};
    localparam logic [3*SEG_W-1:0] FRAME_B = {27'h0F0F0F3, 27'h4B2E991, 27'h6666661};

    typedef struct packed {
        logic        duplex;
        logic [9:0]  dim;
        logic [1:0]  slot;
        logic [9:0]  bit_t;
        logic [1:0]  sub;
    } vec_t;

    // R4 R5 R6 R7 R2 R1: window edges, clamping, grid order and sub-bit timing
    localparam vec_t VECS [13] = '{
        '{1'b0, 10'd0,    2'd1, 10'd0,    2'd0},
        '{1'b0, 10'd1,    2'd1, 10'd0,    2'd3},
        '{1'b0, 10'd1,    2'd1, 10'd1,    2'd0},
        '{1'b0, 10'd1015, 2'd1, 10'd1014, 2'd2},
        '{1'b0, 10'd1015, 2'd1, 10'd1015, 2'd0},
        '{1'b0, 10'd1023, 2'd1, 10'd1015, 2'd3},
        '{1'b0, 10'd1023, 2'd1, 10'd1016, 2'd0},
        '{1'b0, 10'd512,  2'd2, 10'd100,  2'd1},
        '{1'b1, 10'd300,  2'd2, 10'd10,   2'd0},
        '{1'b0, 10'd1016, 2'd3, 10'd5,    2'd0},
        '{1'b1, 10'd600,  2'd1, 10'd599,  2'd3},
        '{1'b0, 10'd520,  2'd1, 10'd519,  2'd0},
        '{1'b1, 10'd1023, 2'd1, 10'd1020, 2'd0}
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               duplex_sel = 1'b0;
    logic [DIM_W-1:0]   dim_code = '0;
    logic [3*SEG_W-1:0] seg_frame = '0;
    logic [2:0]         grid_n;
    logic [SEG_W-1:0]   seg_out;
    logic               dim_pulse;
    logic [1:0]         sync_idx;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    vfd_grid_dimmer i_vfd_grid_dimmer (
        .clk        (clk),
        .rst        (rst),
        .duplex_sel (duplex_sel),
        .dim_code   (dim_code),
        .seg_frame  (seg_frame),
        .grid_n     (grid_n),
        .seg_out    (seg_out),
        .dim_pulse  (dim_pulse),
        .sync_idx   (sync_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h (edge %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_to(input int m);
        while (cyc < m) @(negedge clk);
    endtask

    task automatic expect_outputs(input string tag, input int idx, input int eff,
                                  input logic [SEG_W-1:0] segs, input int b);
        logic [2:0] exp_gn;
        logic       on;
        on     = (b < eff);
        exp_gn = 3'b111;
        if (b < ON_MAX) exp_gn[idx] = 1'b0;
        check({tag, " R3 grid_n"}, 32'(grid_n), 32'(exp_gn));
        check({tag, " R4 R5 R6 seg_out"}, 32'(seg_out), on ? 32'(segs) : 32'd0);
        check({tag, " R7 dim_pulse"}, 32'(dim_pulse), 32'(on));
        check({tag, " R2 R8 sync_idx"}, 32'(sync_idx), 32'(idx));
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        // R10: reset state with nonzero inputs present
        duplex_sel = 1'b0;
        dim_code   = 10'd700;
        seg_frame  = FRAME_A;
        repeat (3) @(negedge clk);
        check("R10 grid_n", 32'(grid_n), 32'h6);
        check("R10 seg_out", 32'(seg_out), 32'd0);
        check("R10 dim_pulse", 32'(dim_pulse), 32'd0);
        check("R10 sync_idx", 32'(sync_idx), 32'd0);

        // vector table
        for (int i = 0; i < 13; i++) begin
            int m, t, s, b, idx, eff;
            logic [SEG_W-1:0] segs;
            duplex_sel = VECS[i].duplex;
            dim_code   = VECS[i].dim;
            seg_frame  = FRAME_A;
            do_reset();
            m = int'(VECS[i].slot) * SLOT_CLK + int'(VECS[i].bit_t) * BIT_CLK + int'(VECS[i].sub);
            wait_to(m);
            t   = m / BIT_CLK;
            s   = t / SLOT_BITS;
            b   = t % SLOT_BITS;
            idx = VECS[i].duplex ? (s % 2) : (s % 3);
            eff = (s == 0) ? 0 : ((int'(VECS[i].dim) > ON_MAX) ? ON_MAX : int'(VECS[i].dim));
            segs = (s == 0) ? '0 : FRAME_A[idx*SEG_W +: SEG_W];
            expect_outputs($sformatf("vec %0d", i), idx, eff, segs, b);
        end

        // R1: slot boundary lands exactly on edge 4096
        duplex_sel = 1'b0;
        dim_code   = 10'd40;
        seg_frame  = FRAME_A;
        do_reset();
        wait_to(SLOT_CLK - 1);
        check("R1 last clock of slot 0 sync_idx", 32'(sync_idx), 32'd0);
        check("R1 last clock of slot 0 grid_n", 32'(grid_n), 32'h7);
        wait_to(SLOT_CLK);
        check("R1 first clock of slot 1 sync_idx", 32'(sync_idx), 32'd1);
        check("R1 first clock of slot 1 grid_n", 32'(grid_n), 32'h5);
        check("R1 first clock of slot 1 dim_pulse", 32'(dim_pulse), 32'd1);

        // R9: mid-slot changes wait for the next slot
        duplex_sel = 1'b0;
        dim_code   = 10'd1016;
        seg_frame  = FRAME_A;
        do_reset();
        wait_to(SLOT_CLK + 400 * BIT_CLK);
        dim_code  = 10'd10;
        seg_frame = FRAME_B;
        wait_to(SLOT_CLK + 500 * BIT_CLK);
        expect_outputs("R9 old values kept", 1, ON_MAX, FRAME_A[SEG_W +: SEG_W], 500);
        wait_to(2 * SLOT_CLK + 5 * BIT_CLK);
        expect_outputs("R9 new values in next slot", 2, 10, FRAME_B[2*SEG_W +: SEG_W], 5);
        wait_to(2 * SLOT_CLK + 500 * BIT_CLK);
        expect_outputs("R9 new window end", 2, 10, FRAME_B[2*SEG_W +: SEG_W], 500);

        // R10: reset in the middle of a lit slot
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R10 mid-run grid_n", 32'(grid_n), 32'h6);
        check("R10 mid-run seg_out", 32'(seg_out), 32'd0);
        check("R10 mid-run sync_idx", 32'(sync_idx), 32'd0);
        rst = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule